// File: doc/BRIEF.md
# Smart panel frame writer

This block pushes one frame of pixels to a display panel that keeps its own frame memory, using a parallel write bus with an active-low chip select and an active-low write strobe. Every pixel is written in four timed phases: chip-select setup, strobe setup, strobe active and strobe hold. The length of each phase comes from a configuration word. Pixels arrive on a ready/valid stream. A frame is a programmed number of columns times rows.

A frame starts in one of two ways. The first is a software command. The second is a hardware path, fed either by an explicit trigger pulse or by each rising edge of the panel's tearing-effect line, and that path can be masked. While a frame is in flight the block is busy and ignores every further start request, because a repeated start would upset the panel. At the end of the frame it raises a one-cycle done pulse (when the interrupt is enabled) and sets a sticky status bit. Busy always clears at frame end, whether or not the interrupt is enabled.

Top module: `smart_panel_writer`

## Requirements
- R1: Configuration word fields are 4-bit phase counts: chip-select setup at [19:16], strobe setup at [15:12], strobe active at [11:8] and strobe hold at [7:4]. A count N lasts N+1 clock cycles. For each pixel, `lcd_cs_n` is low for (setup counts + 2) cycles before `lcd_wr_n` falls. `lcd_wr_n` is low for active+1 cycles. `lcd_cs_n` stays low for hold+1 cycles after `lcd_wr_n` rises. `lcd_wr_n` is never low while `lcd_cs_n` is high.
- R2: After reset the phase counts are setup 0, strobe setup 0, active 1 and hold 0. The configuration word is written per byte lane through `cfg_be`, so setting only byte 0 keeps these defaults.
- R3: Configuration bit 0 enables the interface. While it is clear, `lcd_cs_n` and `lcd_wr_n` stay high and start requests are ignored. Clearing it mid-frame returns the block to idle with no done pulse.
- R4: In software mode, a trigger-control write with bit 0 (software mode) and bit 1 (command) both set starts a frame, provided the block is enabled and idle.
- R5: While busy, every start request (software, hardware or tearing-effect) is ignored.
- R6: A frame writes exactly `frame_w`×`frame_h` pixels, in the order they were accepted on the stream. `lcd_data` holds the accepted pixel across its strobe. `busy` falls right after the last hold phase.
- R7: Hardware trigger mode has trigger-control bit 0 clear and bit 3 set. A one-cycle `hw_trig_in` then starts a frame. Bit 4 set masks all hardware starts.
- R8: In hardware trigger mode with bit 31 set, each rising edge of `te_in` starts a frame when the block is idle and unmasked. With bit 31 clear, `te_in` starts nothing.
- R9: With `irq_en` high, `irq_pulse` is high for exactly one cycle per completed frame, and `irq_stat` is set on the cycle after it. `irq_stat` stays set until `irq_clr` is pulsed; a set in the same cycle wins.
- R10: With `irq_en` low, no `irq_pulse` occurs and `irq_stat` is not set, but `busy` still clears at frame end.
- R11: A start request while `frame_w` or `frame_h` is zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_be | input | 4 | Byte-lane enables for the configuration write |
| cfg_wdata | input | 32 | Configuration word: phase counts and interface enable |
| trg_we | input | 1 | Trigger-control write strobe |
| trg_wdata | input | 32 | Trigger control: software mode, command, hardware enable, mask, per-edge enable |
| hw_trig_in | input | 1 | Hardware start pulse |
| te_in | input | 1 | Tearing-effect line from the panel |
| frame_w | input | DIM_W | Pixels per row |
| frame_h | input | DIM_W | Rows per frame |
| pix_valid | input | 1 | Pixel stream valid |
| pix_data | input | DATA_W | Pixel stream data |
| pix_ready | output | 1 | Pixel stream ready |
| irq_en | input | 1 | Frame-done interrupt enable |
| irq_clr | input | 1 | Clears the sticky done status |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_data | output | DATA_W | Panel data bus |
| busy | output | 1 | Frame transfer in flight |
| irq_pulse | output | 1 | One-cycle frame-done interrupt |
| irq_stat | output | 1 | Sticky frame-done status |

## Verification
The bench streams frames under three sets of conditions. The reset-default phase timing is used with a stream that is never stalled. A distinct nonzero count in every phase is used with a stream that drops valid on every third cycle, which separates the four phase lengths from one another and from stream back-pressure. A scoreboard compares each strobed word with the accepted pixel order. Start requests are then issued from each source (software command, hardware pulse, masked pulse, tearing-effect edge with and without per-edge enable), during busy, with a zero dimension, with the interrupt disabled, and by disabling the interface mid-frame. Each of these tells apart which start path was taken and whether the busy lock held.

// File: rtl/spw_pkg.sv
package spw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_CSS   = 3'd2,
    ST_WRS   = 3'd3,
    ST_ACT   = 3'd4,
    ST_HLD   = 3'd5
  } spw_state_e;

  typedef struct packed {
    logic [3:0] cs_setup;
    logic [3:0] wr_setup;
    logic [3:0] wr_active;
    logic [3:0] wr_hold;
  } spw_phase_t;

  // field positions the phase sequencer decodes
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_HLD_LSB  = 4;
  localparam int CFG_ACT_LSB  = 8;
  localparam int CFG_WRS_LSB  = 12;
  localparam int CFG_CSS_LSB  = 16;

  localparam int TRG_SW_MODE  = 0;
  localparam int TRG_SW_CMD   = 1;
  localparam int TRG_HW_EN    = 3;
  localparam int TRG_HW_MASK  = 4;
  localparam int TRG_PER_TE   = 31;

  // reset word: active count 1, everything else 0, interface off
  localparam logic [31:0] CFG_RESET = 32'h0000_0100;

  function automatic spw_phase_t unpack_phases(input logic [31:0] w);
    spw_phase_t p;
    p.cs_setup  = w[CFG_CSS_LSB +: 4];
    p.wr_setup  = w[CFG_WRS_LSB +: 4];
    p.wr_active = w[CFG_ACT_LSB +: 4];
    p.wr_hold   = w[CFG_HLD_LSB +: 4];
    return p;
  endfunction

endpackage

// File: rtl/spw_cfg_regs.sv
module spw_cfg_regs
  import spw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic        trg_we,
  input  logic [31:0] trg_wdata,
  output spw_phase_t  phases,
  output logic        if_en,
  output logic        trg_sw_mode,
  output logic        trg_hw_en,
  output logic        trg_hw_mask,
  output logic        trg_per_te,
  output logic        sw_cmd
);
  localparam int LANES = 4;

  logic [31:0] cfg_q;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[8*b +: 8] <= CFG_RESET[8*b +: 8];
      else if (cfg_we && cfg_be[b])
        cfg_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_sw_mode <= 1'b0;
      trg_hw_en   <= 1'b0;
      trg_hw_mask <= 1'b0;
      trg_per_te  <= 1'b0;
    end else if (trg_we) begin
      trg_sw_mode <= trg_wdata[TRG_SW_MODE];
      trg_hw_en   <= trg_wdata[TRG_HW_EN];
      trg_hw_mask <= trg_wdata[TRG_HW_MASK];
      trg_per_te  <= trg_wdata[TRG_PER_TE];
    end
  end

  // command bit acts only in the write cycle, and only together with software mode
  assign sw_cmd = trg_we && trg_wdata[TRG_SW_MODE] && trg_wdata[TRG_SW_CMD];
  assign phases = unpack_phases(cfg_q);
  assign if_en  = cfg_q[CFG_EN_BIT];

  logic unused_bits;
  assign unused_bits = ^{cfg_q[31:20], cfg_q[3:1], trg_wdata[30:5], trg_wdata[2]};
endmodule

// File: rtl/spw_trig_arb.sv
module spw_trig_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic if_en,
  input  logic size_ok,
  input  logic engine_busy,
  input  logic trg_sw_mode,
  input  logic trg_hw_en,
  input  logic trg_hw_mask,
  input  logic trg_per_te,
  input  logic sw_cmd,
  input  logic hw_trig_in,
  input  logic te_in,
  output logic te_rise,
  output logic start_go
);
  logic te_q;
  logic hw_path_open;
  logic hw_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) te_q <= 1'b0;
    else        te_q <= te_in;
  end

  assign te_rise      = te_in && !te_q;
  assign hw_path_open = !trg_sw_mode && trg_hw_en && !trg_hw_mask;
  assign hw_req       = hw_path_open && (hw_trig_in || (trg_per_te && te_rise));
  // repeat requests are dropped while a frame is in flight
  assign start_go     = if_en && size_ok && !engine_busy && (sw_cmd || hw_req);
endmodule

// File: rtl/spw_strobe_fsm.sv
module spw_strobe_fsm
  import spw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_en,
  input  logic              start_go,
  input  spw_phase_t        phases,
  input  logic [DIM_W-1:0]  frame_w,
  input  logic [DIM_W-1:0]  frame_h,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              cs_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] lcd_data,
  output logic              busy,
  output logic              size_ok,
  output logic              frame_end
);
  localparam int CW = 2 * DIM_W;

  function automatic logic [CW-1:0] frame_pixels(input logic [DIM_W-1:0] w,
                                                 input logic [DIM_W-1:0] h);
    return CW'(w) * CW'(h);
  endfunction

  spw_state_e        state;
  logic [3:0]        ph_cnt;
  logic [CW-1:0]     pix_idx;
  logic [CW-1:0]     tot_q;
  logic [DATA_W-1:0] data_q;
  logic              ph_done;
  logic              last_pix;

  assign ph_done  = (ph_cnt == 4'd0);
  assign last_pix = (pix_idx + CW'(1)) == tot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ph_cnt  <= '0;
      pix_idx <= '0;
      tot_q   <= '0;
      data_q  <= '0;
    end else if (!if_en) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (start_go) begin
          state   <= ST_FETCH;
          pix_idx <= '0;
          tot_q   <= frame_pixels(frame_w, frame_h);
        end
        ST_FETCH: if (pix_valid) begin
          data_q <= pix_data;
          ph_cnt <= phases.cs_setup;
          state  <= ST_CSS;
        end
        ST_CSS: if (ph_done) begin
          ph_cnt <= phases.wr_setup;
          state  <= ST_WRS;
        end else ph_cnt <= ph_cnt - 4'd1;
        ST_WRS: if (ph_done) begin
          ph_cnt <= phases.wr_active;
          state  <= ST_ACT;
        end else ph_cnt <= ph_cnt - 4'd1;
        ST_ACT: if (ph_done) begin
          ph_cnt <= phases.wr_hold;
          state  <= ST_HLD;
        end else ph_cnt <= ph_cnt - 4'd1;
        ST_HLD: if (ph_done) begin
          if (last_pix) state <= ST_IDLE;
          else begin
            pix_idx <= pix_idx + CW'(1);
            state   <= ST_FETCH;
          end
        end else ph_cnt <= ph_cnt - 4'd1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign pix_ready = (state == ST_FETCH) && if_en;
  assign cs_n      = !(state == ST_CSS || state == ST_WRS || state == ST_ACT || state == ST_HLD);
  assign wr_n      = (state != ST_ACT);
  assign lcd_data  = data_q;
  assign size_ok   = (frame_w != '0) && (frame_h != '0);
  assign frame_end = if_en && (state == ST_HLD) && ph_done && last_pix;
endmodule

// File: rtl/smart_panel_writer.sv
module smart_panel_writer
  import spw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  input  logic              trg_we,
  input  logic [31:0]       trg_wdata,
  input  logic              hw_trig_in,
  input  logic              te_in,
  input  logic [DIM_W-1:0]  frame_w,
  input  logic [DIM_W-1:0]  frame_h,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n,
  output logic [DATA_W-1:0] lcd_data,
  output logic              busy,
  output logic              irq_pulse,
  output logic              irq_stat
);
  spw_phase_t phases;
  logic if_en, trg_sw_mode, trg_hw_en, trg_hw_mask, trg_per_te, sw_cmd;
  logic te_rise, start_go, size_ok, frame_end;

  spw_cfg_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_be, .cfg_wdata, .trg_we, .trg_wdata,
    .phases, .if_en, .trg_sw_mode, .trg_hw_en, .trg_hw_mask, .trg_per_te, .sw_cmd
  );

  spw_trig_arb u_arb (
    .clk, .rst_n, .if_en, .size_ok, .engine_busy(busy),
    .trg_sw_mode, .trg_hw_en, .trg_hw_mask, .trg_per_te,
    .sw_cmd, .hw_trig_in, .te_in, .te_rise, .start_go
  );

  spw_strobe_fsm #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_fsm (
    .clk, .rst_n, .if_en, .start_go, .phases, .frame_w, .frame_h,
    .pix_valid, .pix_data, .pix_ready, .cs_n(lcd_cs_n), .wr_n(lcd_wr_n),
    .lcd_data, .busy, .size_ok, .frame_end
  );

  assign irq_pulse = frame_end && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_stat <= 1'b0;
    else if (irq_pulse) irq_stat <= 1'b1;
    else if (irq_clr)   irq_stat <= 1'b0;
  end
endmodule

// File: rtl/spw_checker.sv
module spw_checker (
  input logic clk,
  input logic rst_n,
  input logic lcd_cs_n,
  input logic lcd_wr_n,
  input logic busy,
  input logic if_en,
  input logic start_go,
  input logic frame_end,
  input logic pix_ready,
  input logic irq_en,
  input logic irq_pulse,
  input logic irq_stat
);
  AST_WR_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> !lcd_cs_n);                                             // R1
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> (lcd_cs_n && lcd_wr_n));                                   // R3
  AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> busy);                                                   // R4
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_go);                                                  // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy);                                                 // R6
  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> busy);                                                  // R6
  AST_BUSY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(frame_end) || !$past(if_en)));                 // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> irq_stat);                                              // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_pulse);                                              // R10
endmodule

bind smart_panel_writer spw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
  .busy(busy), .if_en(if_en), .start_go(start_go), .frame_end(frame_end),
  .pix_ready(pix_ready), .irq_en(irq_en), .irq_pulse(irq_pulse), .irq_stat(irq_stat)
);

// File: tb/smart_panel_writer_tb_top.sv
`timescale 1ns/1ps
module smart_panel_writer_tb_top;
  localparam int DATA_W = 16;
  localparam int DIM_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, trg_we = 1'b0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0, trg_wdata = '0;
  logic hw_trig_in = 1'b0, te_in = 1'b0;
  logic [DIM_W-1:0] frame_w = '0, frame_h = '0;
  logic pix_valid = 1'b0;
  logic [DATA_W-1:0] pix_data = '0;
  logic pix_ready;
  logic irq_en = 1'b0, irq_clr = 1'b0;
  logic lcd_cs_n, lcd_wr_n, busy, irq_pulse, irq_stat;
  logic [DATA_W-1:0] lcd_data;

  always #10 clk = ~clk;  // 50 MHz

  smart_panel_writer #(.DATA_W(DATA_W), .DIM_W(DIM_W)) dut_i (
    .clk, .rst_n, .cfg_we, .cfg_be, .cfg_wdata, .trg_we, .trg_wdata,
    .hw_trig_in, .te_in, .frame_w, .frame_h, .pix_valid, .pix_data, .pix_ready,
    .irq_en, .irq_clr, .lcd_cs_n, .lcd_wr_n, .lcd_data, .busy, .irq_pulse, .irq_stat
  );

  int n_checks = 0, n_fail = 0;
  int exp_css = 0, exp_wrs = 0, exp_act = 1, exp_hld = 0;
  int wr_count = 0, irq_count = 0;
  bit src_on = 0, stall = 0, mon_on = 1;
  int seq = 0, cyc = 0;
  logic [DATA_W-1:0] exp_q[$];

  function automatic logic [DATA_W-1:0] pattern(input int s);
    return DATA_W'(16'hA500 ^ (s * 16'h0137));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // driver: offers pixels and pushes accepted ones into the scoreboard
  initial begin
    forever begin
      bit took;
      @(negedge clk);
      took = pix_valid && pix_ready;
      if (took) exp_q.push_back(pix_data);
      @(posedge clk);
      #1;
      cyc++;
      if (took) seq++;
      pix_valid = src_on && !(stall && (cyc % 3 == 0));
      pix_data  = pattern(seq);
    end
  end

  // monitor: phase widths, data order, interrupt pulses
  initial begin
    logic prev_cs = 1'b1, prev_wr = 1'b1;
    int pre = 0, wl = 0, hl = 0;
    bit post = 0;
    forever begin
      @(negedge clk);
      if (irq_pulse) irq_count++;
      if (prev_wr == 1'b0 && lcd_wr_n == 1'b1) begin
        logic [DATA_W-1:0] e;
        wr_count++;
        post = 1;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
        if (mon_on) begin
          chk(lcd_data === e, "R6 data order", int'(lcd_data), int'(e));
          chk(wl == exp_act + 1, "R1 strobe active width", wl, exp_act + 1);
          chk(pre == exp_css + exp_wrs + 2, "R1 setup width", pre, exp_css + exp_wrs + 2);
        end
      end
      if (prev_cs == 1'b0 && lcd_cs_n == 1'b1) begin
        if (mon_on) chk(hl == exp_hld + 1, "R1 hold width", hl, exp_hld + 1);
        pre = 0; wl = 0; hl = 0; post = 0;
      end
      if (lcd_cs_n == 1'b0) begin
        if (lcd_wr_n == 1'b0) wl++;
        else if (!post) pre++;
        else hl++;
      end
      prev_cs = lcd_cs_n;
      prev_wr = lcd_wr_n;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  task automatic cfg_write(input logic [3:0] be, input logic [31:0] d);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic trg_write(input logic [31:0] d);
    @(posedge clk); #1 trg_we = 1'b1; trg_wdata = d;
    @(posedge clk); #1 trg_we = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(posedge clk); #1 s = 1'b1;
    @(posedge clk); #1 s = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int w0, i0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(lcd_cs_n && lcd_wr_n, "R3 reset strobes high", {lcd_cs_n, lcd_wr_n}, 3);
    chk(!busy && !pix_ready, "R3 reset idle", {busy, pix_ready}, 0);
    chk(!irq_stat, "R9 reset status", irq_stat, 0);

    // disabled interface ignores the software command
    src_on = 1; frame_w = 3; frame_h = 2;
    trg_write(32'h3);
    repeat (20) @(negedge clk);
    chk(wr_count == 0 && !busy, "R3 no activity while disabled", wr_count, 0);

    // byte-lane enable keeps default phases (R2), software start (R4)
    irq_en = 1;
    cfg_write(4'b0001, 32'h01);
    trg_write(32'h3);
    wait_idle();
    chk(wr_count == 6, "R2 R6 default-timing frame count", wr_count, 6);
    chk(exp_q.size() == 0, "R6 all accepted pixels written", exp_q.size(), 0);
    chk(irq_count == 1, "R9 one done pulse", irq_count, 1);
    chk(irq_stat, "R9 sticky status set", irq_stat, 1);
    pulse(irq_clr);
    @(negedge clk);
    chk(!irq_stat, "R9 status cleared", irq_stat, 0);

    // distinct phase counts with a stalling stream (R1)
    exp_css = 2; exp_wrs = 1; exp_act = 3; exp_hld = 2;
    stall = 1;
    cfg_write(4'b1111, 32'h0002_1321);
    frame_w = 4; frame_h = 1;
    w0 = wr_count;
    trg_write(32'h3);
    wait_idle();
    chk(wr_count - w0 == 4, "R1 R6 stalled frame count", wr_count - w0, 4);

    // repeat triggers during busy are dropped (R5)
    frame_w = 5; frame_h = 3;
    w0 = wr_count; i0 = irq_count;
    trg_write(32'h3);
    repeat (10) @(posedge clk);
    trg_write(32'h3);
    trg_write(32'h3);
    wait_idle();
    chk(wr_count - w0 == 15, "R5 retrigger ignored count", wr_count - w0, 15);
    chk(irq_count - i0 == 1, "R5 single done", irq_count - i0, 1);
    pulse(irq_clr);

    // interrupt disabled: busy still clears, no pulse (R10)
    irq_en = 0; frame_w = 2; frame_h = 2;
    w0 = wr_count; i0 = irq_count;
    trg_write(32'h3);
    wait_idle();
    chk(!busy && wr_count - w0 == 4, "R10 busy clears without irq", wr_count - w0, 4);
    chk(irq_count == i0 && !irq_stat, "R10 no pulse or status", irq_count - i0, 0);
    irq_en = 1;

    // zero dimension ignored (R11)
    frame_w = 0; frame_h = 3;
    w0 = wr_count;
    trg_write(32'h3);
    repeat (10) @(negedge clk);
    chk(!busy && wr_count == w0, "R11 zero width ignored", wr_count - w0, 0);
    frame_w = 3; frame_h = 1;

    // hardware path masked, then open (R7)
    trg_write(32'h18);
    w0 = wr_count;
    pulse(hw_trig_in);
    repeat (10) @(negedge clk);
    chk(!busy && wr_count == w0, "R7 masked hardware start ignored", wr_count - w0, 0);
    trg_write(32'h08);
    pulse(hw_trig_in);
    wait_idle();
    chk(wr_count - w0 == 3, "R7 hardware start frame", wr_count - w0, 3);

    // tearing-effect edge without and with per-edge enable (R8)
    w0 = wr_count;
    pulse(te_in);
    repeat (10) @(negedge clk);
    chk(!busy && wr_count == w0, "R8 edge ignored without enable", wr_count - w0, 0);
    trg_write(32'h8000_0008);
    pulse(te_in);
    wait_idle();
    chk(wr_count - w0 == 3, "R8 first edge frame", wr_count - w0, 3);
    pulse(te_in);
    wait_idle();
    chk(wr_count - w0 == 6, "R8 second edge frame", wr_count - w0, 6);

    // disable mid-frame: back to idle, no done (R3)
    trg_write(32'h3);
    frame_w = 4; frame_h = 4;
    i0 = irq_count;
    pulse(irq_clr);
    mon_on = 0;
    trg_write(32'h3);
    repeat (15) @(posedge clk);
    cfg_write(4'b0001, 32'h00);
    repeat (3) @(negedge clk);
    chk(!busy && lcd_cs_n && lcd_wr_n, "R3 abort to idle", busy, 0);
    chk(irq_count == i0 && !irq_stat, "R3 abort raises no done", irq_count - i0, 0);
    exp_q.delete();

    report();
  end
endmodule